// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel sample words. It watches three synchronous lines: a data line carrying two's-complement samples MSB first, a word-select line whose level tells which channel is on the data line and whose frequency is the sample rate, and a bit clock. Data is taken on each rising bit-clock edge. One shift engine handles three framings, chosen by a static format input. The first is I2S-style framing, where the MSB comes one bit after the word-select change. The second is left-justified framing, where the MSB sits in the first bit after the change. The third is right-justified 16-bit framing, where only the last 16 bits before each word-select change are kept.

The bit clock is either an external pin or an internal generator. The generator runs on the system clock, ticks once every `bclk_div` system cycles, and restarts on each word-select change. A frame may have 32, 48, 64 or 72 bit clocks per sample period. The receiver presents a 24-bit left word and a 24-bit right word, and one valid strobe per stereo frame. All three lines are taken to be synchronous to `clk` and are sampled by it.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first frame completes, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: With `fmt` = 0 (I2S-style), word-select low carries the left word and high carries the right word. The MSB of each word is taken on the second bit-clock rising edge after the word-select change, and the word ends with the bit on the first edge after the next change.
- R3: With `fmt` = 1 (left-justified; code 3 behaves the same), word-select high carries the left word. The MSB is taken on the first rising edge after the word-select change.
- R4: With `fmt` = 2 (right-justified), word-select high carries the left word. The 16 bits taken on the last 16 rising edges before each word-select change form the word, which is output as bits 23:8 with bits 7:0 zero. Earlier bits of the channel slot are ignored.
- R5: In formats 0 and 1, bits after the 24th of a channel slot are ignored. When a slot has fewer than 24 bits, the word is left-aligned and the missing low bits read zero.
- R6: `valid_o` is high for exactly one `clk` cycle per stereo frame, in the cycle after the right word completes. `left_o` and `right_o` change only in that cycle and then hold.
- R7: Frames of 32, 48, 64 and 72 bit clocks per sample period are received correctly.
- R8: With `bclk_ext_sel` = 1, the data line is sampled on the rising edges of `bclk_in`. With `bclk_ext_sel` = 0, the internal bit period is `bclk_div` (at least 2) `clk` cycles. Its phase restarts whenever word-select changes, and the data line is sampled at phase `bclk_div`/2.
- R9: The channel slot in progress when reception starts is discarded. The first `valid_o` comes only after a full left word and then a full right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Framing: 0 I2S-style, 1 left-justified, 2 right-justified 16-bit |
| bclk_ext_sel | input | 1 | 1: use `bclk_in`; 0: use internal bit-clock generator |
| bclk_div | input | DIV_W | Internal bit period in `clk` cycles |
| bclk_in | input | 1 | External bit clock |
| ws_in | input | 1 | Word-select (frame) clock |
| sd_in | input | 1 | Serial data |
| left_o | output | WORD_W | Left sample, left-aligned |
| right_o | output | WORD_W | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
The assertions assume that `fmt` stays fixed between resets. They also assume that rising bit-clock edges never occur on two consecutive `clk` cycles, which holds for an external bit clock seen through one register stage and for an internal divider of 2 or more. The bench changes the format only under reset. It holds each external bit-clock level for three `clk` cycles, and in internal mode it holds each bit for exactly `bclk_div` cycles, starting at a word-select change. With these conditions the single-cycle strobe and the hold properties are checked only on streams that the block can frame correctly.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W = 24,
  parameter int RJ_W   = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt,
  input  logic              bclk_ext_sel,
  input  logic [DIV_W-1:0]  bclk_div,
  input  logic              bclk_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int PAD_W = WORD_W - RJ_W;
  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  logic bclk_r, bclk_p, ws_r, ws_p, sd_r;
  logic [DIV_W-1:0] div_cnt, phase;
  logic tick, ext_tick, int_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_r <= 1'b0; bclk_p <= 1'b0;
      ws_r   <= 1'b0; ws_p   <= 1'b0;
      sd_r   <= 1'b0;
    end else begin
      bclk_r <= bclk_in; bclk_p <= bclk_r;
      ws_r   <= ws_in;   ws_p   <= ws_r;
      sd_r   <= sd_in;
    end

  assign ext_tick = bclk_r & ~bclk_p;
  assign phase    = (ws_r != ws_p) ? '0 : div_cnt;
  assign int_tick = (phase == (bclk_div >> 1));
  assign tick     = bclk_ext_sel ? ext_tick : int_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else if (phase >= bclk_div - 1'b1) div_cnt <= '0;
    else div_cnt <= phase + 1'b1;

  logic ws_t, eff_prev, eff_ws, chg, started, have_l, left_lvl, is_rj;
  logic [1:0] prime;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] acc, pend_l, word_done;
  logic [RJ_W-1:0] sreg;

  assign is_rj     = (fmt == FMT_RJ);
  assign left_lvl  = (fmt != FMT_I2S);
  assign eff_ws    = (fmt == FMT_I2S) ? ws_t : ws_r;
  assign chg       = (prime == 2'd2) && (eff_ws != eff_prev);
  assign word_done = is_rj ? {sreg, {PAD_W{1'b0}}} : acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ws_t <= 1'b0; eff_prev <= 1'b0; prime <= '0; started <= 1'b0;
      cnt <= '0; acc <= '0; sreg <= '0;
    end else if (tick) begin
      ws_t     <= ws_r;
      eff_prev <= eff_ws;
      sreg     <= {sreg[RJ_W-2:0], sd_r};
      if (prime != 2'd2) prime <= prime + 1'b1;
      if (chg) begin
        started <= 1'b1;
        acc     <= {sd_r, {(WORD_W-1){1'b0}}};
        cnt     <= CNT_W'(1);
      end else if (cnt < CNT_W'(WORD_W)) begin
        acc[WORD_W-1-int'(cnt)] <= sd_r;
        cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_l <= '0; have_l <= 1'b0;
      left_o <= '0; right_o <= '0; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick && chg && started) begin
        if (eff_prev == left_lvl) begin
          pend_l <= word_done;
          have_l <= 1'b1;
        end else if (have_l) begin
          left_o  <= pend_l;
          right_o <= word_done;
          valid_o <= 1'b1;
          have_l  <= 1'b0;
        end
      end
    end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_rj_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && is_rj) |-> (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));

  assert_valid_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(tick));

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));

endmodule

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic ext = 1'b1;
  logic [7:0] div = 8'd4;
  logic bclk = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o;

  int errors = 0, checks = 0, nval = 0, dbl = 0;
  logic [23:0] got_l [0:3];
  logic [23:0] got_r [0:3];
  logic prev_v = 1'b0, prev_lj = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bclk_ext_sel(ext), .bclk_div(div),
    .bclk_in(bclk), .ws_in(ws), .sd_in(sd),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

  always @(negedge clk) begin
    if (valid_o) begin
      if (nval < 4) begin got_l[nval] = left_o; got_r[nval] = right_o; end
      nval++;
      if (prev_v) dbl++;
    end
    prev_v = valid_o;
  end

  task automatic check(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic d);
    logic s;
    s = d;
    if (fmt == 2'd0) begin s = prev_lj; prev_lj = d; end
    @(negedge clk);
    ws = w; sd = s;
    if (ext) begin
      bclk = 1'b0;
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (2) @(negedge clk);
    end else begin
      repeat (int'(div) - 1) @(negedge clk);
    end
  endtask

  function automatic logic slot_bit(input logic [23:0] w, input int slots, input int i);
    if (fmt == 2'd2) return (i >= slots - 16) ? w[23 - (i - (slots - 16))] : 1'b1;
    return (i < 24) ? w[23 - i] : 1'b1;
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] w, input int slots);
    if (fmt == 2'd2) return {w[23:8], 8'h00};
    if (slots >= 24) return w;
    return w & ~((24'h1 << (24 - slots)) - 24'h1);
  endfunction

  task automatic run_case(input string name, input logic [1:0] f, input logic e, input logic [7:0] dv,
                          input int frame_len, input logic [23:0] l0, input logic [23:0] r0,
                          input logic [23:0] l1, input logic [23:0] r1);
    int slots;
    logic lw, rw;
    logic [23:0] ls [0:1];
    logic [23:0] rs [0:1];
    ls[0] = l0; ls[1] = l1; rs[0] = r0; rs[1] = r1;
    slots = frame_len / 2;
    rst_n = 1'b0; fmt = f; ext = e; div = dv; bclk = 1'b0; prev_lj = 1'b0;
    lw = (f != 2'd0); rw = ~lw;
    ws = rw; sd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    nval = 0; dbl = 0;
    for (int i = 0; i < 5; i++) send_bit(rw, 1'b1);
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < slots; i++) send_bit(lw, slot_bit(ls[k], slots, i));
      for (int i = 0; i < slots; i++) send_bit(rw, slot_bit(rs[k], slots, i));
    end
    for (int i = 0; i < 4; i++) send_bit(lw, 1'b0);
    repeat (10) @(negedge clk);
    check(nval == 2, {name, " R9 R6 frame count"}, 24'(nval), 24'd2);
    check(dbl == 0, {name, " R6 single-cycle strobe"}, 24'(dbl), 24'd0);
    check(got_l[0] == expect_word(l0, slots), {name, " left word 0"}, got_l[0], expect_word(l0, slots));
    check(got_r[0] == expect_word(r0, slots), {name, " right word 0"}, got_r[0], expect_word(r0, slots));
    check(got_l[1] == expect_word(l1, slots), {name, " left word 1"}, got_l[1], expect_word(l1, slots));
    check(got_r[1] == expect_word(r1, slots), {name, " right word 1"}, got_r[1], expect_word(r1, slots));
    check(left_o == expect_word(l1, slots), {name, " R6 left holds"}, left_o, expect_word(l1, slots));
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(left_o == 24'h0, "R1 reset left", left_o, 24'h0);
    check(right_o == 24'h0, "R1 reset right", right_o, 24'h0);
    check(valid_o == 1'b0, "R1 reset valid", 24'(valid_o), 24'h0);
  endtask

  initial begin
    test_reset();
    run_case("R2 R5 R7 i2s ext 32",   2'd0, 1'b1, 8'd4, 32, 24'hA5C3F0, 24'h5A3C0F, 24'h800001, 24'h7FFFFE);
    run_case("R2 R7 i2s ext 48",      2'd0, 1'b1, 8'd4, 48, 24'h123456, 24'hFEDCBA, 24'h800000, 24'h000001);
    run_case("R3 R5 lj ext 64",       2'd1, 1'b1, 8'd4, 64, 24'hC0FFEE, 24'h0BADF0, 24'hFFFFFF, 24'h000000);
    run_case("R3 R8 R7 lj int 72",    2'd1, 1'b0, 8'd4, 72, 24'h13579B, 24'h2468AC, 24'h7F00FF, 24'h80FF00);
    run_case("R4 R7 rj ext 32",       2'd2, 1'b1, 8'd4, 32, 24'hBEEF00, 24'h1234AB, 24'h8001CD, 24'h7FFE12);
    run_case("R4 R8 rj int 48",       2'd2, 1'b0, 8'd5, 48, 24'hCAFE77, 24'h0F0F33, 24'hF0F011, 24'h55AA99);
    run_case("R2 R8 i2s int 64",      2'd0, 1'b0, 8'd2, 64, 24'h6B6B6B, 24'h949494, 24'h000100, 24'hFF00FF);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule